// File: doc/BRIEF.md
# Packed Quadword Narrowing Unit

This block narrows a vector of 64-bit integer lanes into 32-bit lanes. One of three policies applies to every lane: keep the low half (truncation), clamp to the signed 32-bit range, or clamp to the unsigned 32-bit range. The narrowed lanes are packed side by side from the least-significant end of a 512-bit result. A per-lane mask decides which lanes are written. A masked-off lane either reads as zero or keeps the old destination lane, depending on a zeroing control. Every bit above the packed lanes is cleared.

The unit sits in a vector execution pipe. The front end presents one operation per cycle with `in_valid`, and the registered result appears with `out_valid` one cycle later. A 4-bit reserved field arrives with each operation. When that field is not all ones, or when a reserved select code is used, the operation is flagged invalid and the old destination passes through unchanged.

Top module: `qw_narrow_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. After reset, `out_valid`, `bad_op` and `dst_vec` are all zero.
- R2: `vl_sel` 0, 1 and 2 select 2, 4 and 8 converted lanes (128-, 256- and 512-bit sources). Result lanes at or above that count are zero whatever the mask, and bits 511:256 of `dst_vec` are always zero on a valid operation.
- R3: With `mode_sel` = 0 (truncate, opcode byte 0x35), a written lane is bits 31:0 of its source lane.
- R4: With `mode_sel` = 1 (signed saturate, opcode byte 0x25), the source lane is read as a signed 64-bit value and clamped to 0x80000000..0x7FFFFFFF. In-range values pass their low 32 bits through.
- R5: With `mode_sel` = 2 (unsigned saturate, opcode byte 0x15), an unsigned source lane above 0xFFFFFFFF gives 0xFFFFFFFF. Otherwise the lane passes its low 32 bits through.
- R6: Source lane i, at `src_vec[64i+63:64i]`, lands in result lane i, at `dst_vec[32i+31:32i]`.
- R7: A converted lane is written only when `lane_mask[i]` is 1. With `zero_mode` = 1, a lane whose mask bit is 0 becomes 0.
- R8: With `zero_mode` = 0, a converted lane whose mask bit is 0 takes `dst_old[32i+31:32i]`.
- R9: When `rsv_bits` is not 4'b1111, or `mode_sel` = 3, or `vl_sel` = 3, the unit raises `bad_op`. `dst_vec` then equals the full 512-bit `dst_old` of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| src_vec | input | 512 | Eight 64-bit source lanes |
| vl_sel | input | 2 | Source length: 0=128, 1=256, 2=512 bits |
| mode_sel | input | 2 | 0 truncate, 1 signed saturate, 2 unsigned saturate |
| lane_mask | input | 8 | Per-lane write enable |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| dst_old | input | 512 | Previous destination value |
| rsv_bits | input | 4 | Reserved field, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| dst_vec | output | 512 | Registered result |
| bad_op | output | 1 | Operation rejected as invalid |

## Verification
The bench builds the unit with its default parameters: 64-bit source lanes, 32-bit result lanes and eight lanes. This makes all three source lengths reachable, along with the 256-bit upper region that must stay clear. The boundary values placed in each lane are 0x7FFFFFFF, 0x80000000, their sign-extended neighbours, 0xFFFFFFFF, 0x100000000 and the extreme 64-bit values. These sit right at the edge where each clamp decision flips. Back-to-back random operations mix all legal selects with sparse masks in both merge and zero modes.

// File: rtl/narrow_pkg.sv
// Shared select encodings for the quadword narrowing unit.
// Assumes: both selects are 2-bit fields decoded by the control module.
package narrow_pkg;
    typedef enum logic [1:0] {
        NM_TRUNC = 2'd0,   // opcode byte 0x35
        NM_SSAT  = 2'd1,   // opcode byte 0x25
        NM_USAT  = 2'd2,   // opcode byte 0x15
        NM_RSVD  = 2'd3
    } nmode_e;

    typedef enum logic [1:0] {
        VL_Q = 2'd0,       // quarter width: 128-bit source
        VL_H = 2'd1,       // half width: 256-bit source
        VL_F = 2'd2,       // full width: 512-bit source
        VL_X = 2'd3        // reserved
    } vlen_e;

    localparam logic [3:0] RSV_OK = 4'b1111;
endpackage

// File: rtl/narrow_lane.sv
// Converts one wide lane to a narrow lane under the selected policy.
// Assumes: SRC_W > DST_W; the reserved mode yields truncation (the result is discarded upstream).
module narrow_lane
    import narrow_pkg::*;
#(
    parameter int SRC_W = 64,
    parameter int DST_W = 32
) (
    input  logic [SRC_W-1:0] lane_in,
    input  nmode_e           mode,
    output logic [DST_W-1:0] lane_out
);
    localparam int HI_S = SRC_W - DST_W + 1;
    localparam int HI_U = SRC_W - DST_W;
    localparam logic [DST_W-1:0] MAX_S = {1'b0, {(DST_W-1){1'b1}}};
    localparam logic [DST_W-1:0] MIN_S = {1'b1, {(DST_W-1){1'b0}}};
    localparam logic [DST_W-1:0] MAX_U = {DST_W{1'b1}};

    logic [HI_S-1:0] top_s;
    logic [HI_U-1:0] top_u;
    logic            fits_s;
    logic            fits_u;

    // Range detection: sign bits above the narrow sign must all agree; unsigned high half must be clear.
    always_comb begin
        top_s  = lane_in[SRC_W-1:DST_W-1];
        top_u  = lane_in[SRC_W-1:DST_W];
        fits_s = (top_s == {HI_S{1'b0}}) || (top_s == {HI_S{1'b1}});
        fits_u = (top_u == {HI_U{1'b0}});
    end

    // Policy select: pass the low half or substitute the clamp limit.
    always_comb begin
        case (mode)
            NM_SSAT: lane_out = fits_s ? lane_in[DST_W-1:0]
                                       : (lane_in[SRC_W-1] ? MIN_S : MAX_S);
            NM_USAT: lane_out = fits_u ? lane_in[DST_W-1:0] : MAX_U;
            default: lane_out = lane_in[DST_W-1:0];
        endcase
    end
endmodule

// File: rtl/narrow_ctrl.sv
// Decodes the length select into per-lane activity and checks operation legality.
// Assumes: LANES divisible by 4; reserved length enables no lane.
module narrow_ctrl
    import narrow_pkg::*;
#(
    parameter int LANES = 8
) (
    input  vlen_e            vl,
    input  nmode_e           mode,
    input  logic [3:0]       rsv,
    output logic [LANES-1:0] active,
    output logic             illegal
);
    localparam int CW = $clog2(LANES + 1);

    logic [CW-1:0] cnt;

    // Lane count for the selected source length.
    always_comb begin
        case (vl)
            VL_Q:    cnt = CW'(LANES / 4);
            VL_H:    cnt = CW'(LANES / 2);
            VL_F:    cnt = CW'(LANES);
            default: cnt = '0;
        endcase
    end

    // Thermometer of lanes below the count.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            active[i] = (i < int'(cnt));
        end
    end

    // Legality: reserved field must be all ones and no reserved select code may be used.
    always_comb begin
        illegal = (rsv != RSV_OK) || (mode == NM_RSVD) || (vl == VL_X);
    end
endmodule

// File: rtl/lane_place.sv
// Places one narrowed lane into the destination: written, zeroed, merged or tail-cleared.
// Assumes: inactive lanes are tail lanes and always read as zero.
module lane_place #(
    parameter int DST_W = 32
) (
    input  logic [DST_W-1:0] conv,
    input  logic [DST_W-1:0] old_lane,
    input  logic             active,
    input  logic             wr_en,
    input  logic             zero_mode,
    output logic [DST_W-1:0] lane_res
);
    // Priority: tail clear, then mask write, then zero or merge.
    always_comb begin
        if (!active)        lane_res = '0;
        else if (wr_en)     lane_res = conv;
        else if (zero_mode) lane_res = '0;
        else                lane_res = old_lane;
    end
endmodule

// File: rtl/qw_narrow_unit.sv
// Top of the quadword narrowing unit: per-lane conversion, mask placement, registered result.
// Assumes: one operation per cycle; the result register holds between operations.
module qw_narrow_unit
    import narrow_pkg::*;
#(
    parameter int SRC_W = 64,
    parameter int DST_W = 32,
    parameter int LANES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [SRC_W*LANES-1:0] src_vec,
    input  logic [1:0]             vl_sel,
    input  logic [1:0]             mode_sel,
    input  logic [LANES-1:0]       lane_mask,
    input  logic                   zero_mode,
    input  logic [SRC_W*LANES-1:0] dst_old,
    input  logic [3:0]             rsv_bits,
    output logic                   out_valid,
    output logic [SRC_W*LANES-1:0] dst_vec,
    output logic                   bad_op
);
    localparam int VEC_W  = SRC_W * LANES;
    localparam int PACK_W = DST_W * LANES;
    localparam int FILL_W = VEC_W - PACK_W;

    nmode_e             mode;
    vlen_e              vl;
    logic [LANES-1:0]   active;
    logic               illegal;
    logic [PACK_W-1:0]  packed_res;
    logic [VEC_W-1:0]   next_res;

    assign mode = nmode_e'(mode_sel);
    assign vl   = vlen_e'(vl_sel);

    narrow_ctrl #(.LANES(LANES)) u_ctrl (
        .vl      (vl),
        .mode    (mode),
        .rsv     (rsv_bits),
        .active  (active),
        .illegal (illegal)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DST_W-1:0] conv;

        narrow_lane #(.SRC_W(SRC_W), .DST_W(DST_W)) u_cvt (
            .lane_in  (src_vec[g*SRC_W +: SRC_W]),
            .mode     (mode),
            .lane_out (conv)
        );

        lane_place #(.DST_W(DST_W)) u_place (
            .conv      (conv),
            .old_lane  (dst_old[g*DST_W +: DST_W]),
            .active    (active[g]),
            .wr_en     (lane_mask[g]),
            .zero_mode (zero_mode),
            .lane_res  (packed_res[g*DST_W +: DST_W])
        );
    end

    // Result select: illegal operations leave the old destination untouched.
    always_comb begin
        if (illegal) next_res = dst_old;
        else         next_res = {{FILL_W{1'b0}}, packed_res};
    end

    // Output register with one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst_vec   <= '0;
            bad_op    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_vec <= next_res;
                bad_op  <= illegal;
            end
        end
    end
endmodule

// File: rtl/qw_narrow_chk.sv
// Protocol and result checker for the narrowing unit, attached by bind.
// Assumes: default lane geometry matches the top module.
module qw_narrow_chk #(
    parameter int SRC_W = 64,
    parameter int DST_W = 32,
    parameter int LANES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [SRC_W*LANES-1:0] dst_old,
    input logic [3:0]             rsv_bits,
    input logic                   mask0,
    input logic                   zero_mode,
    input logic                   out_valid,
    input logic [SRC_W*LANES-1:0] dst_vec,
    input logic                   bad_op
);
    localparam int VEC_W  = SRC_W * LANES;
    localparam int PACK_W = DST_W * LANES;

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (out_valid == $past(in_valid)));

    assert_upper_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !bad_op) |-> (dst_vec[VEC_W-1:PACK_W] == '0));

    assert_lane0_zeroed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !bad_op && $past(zero_mode) && !$past(mask0))
            |-> (dst_vec[DST_W-1:0] == '0));

    assert_rsv_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsv_bits != 4'b1111) |=> bad_op);

    assert_old_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bad_op) |-> (dst_vec == $past(dst_old)));
endmodule

bind qw_narrow_unit qw_narrow_chk #(.SRC_W(SRC_W), .DST_W(DST_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dst_old   (dst_old),
    .rsv_bits  (rsv_bits),
    .mask0     (lane_mask[0]),
    .zero_mode (zero_mode),
    .out_valid (out_valid),
    .dst_vec   (dst_vec),
    .bad_op    (bad_op)
);

// File: tb/sim_qw_narrow_unit.sv
module sim_qw_narrow_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [511:0] res;
        logic         bad;
        string        tag;
        int           cyc;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [1:0]   vl_sel = 2'd2;
    logic [1:0]   mode_sel = 2'd0;
    logic [7:0]   lane_mask = '0;
    logic         zero_mode = 1'b0;
    logic [511:0] dst_old = '0;
    logic [3:0]   rsv_bits = 4'hF;
    logic         out_valid;
    logic [511:0] dst_vec;
    logic         bad_op;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   done = 0;
    exp_t sb[$];

    qw_narrow_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .vl_sel(vl_sel), .mode_sel(mode_sel), .lane_mask(lane_mask),
        .zero_mode(zero_mode), .dst_old(dst_old), .rsv_bits(rsv_bits),
        .out_valid(out_valid), .dst_vec(dst_vec), .bad_op(bad_op)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference: narrow one lane by value comparison.
    function automatic logic [31:0] ref_lane(input logic [63:0] v, input logic [1:0] md);
        longint sv;
        sv = v;
        if (md == 2'd1) begin
            if (sv > 64'sd2147483647)       return 32'h7FFFFFFF;
            else if (sv < -64'sd2147483648) return 32'h80000000;
            else                            return v[31:0];
        end else if (md == 2'd2) begin
            if (v > 64'h00000000FFFFFFFF) return 32'hFFFFFFFF;
            else                          return v[31:0];
        end
        return v[31:0];
    endfunction

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [511:0] s, input logic [1:0] vl, input logic [1:0] md,
                         input logic [7:0] m, input logic z, input logic [511:0] o,
                         input logic [3:0] r, input string tag);
        exp_t e;
        int   n;
        @(negedge clk);
        src_vec = s; vl_sel = vl; mode_sel = md; lane_mask = m;
        zero_mode = z; dst_old = o; rsv_bits = r; in_valid = 1'b1;
        e.tag = tag;
        e.cyc = cyc;
        e.bad = (r != 4'hF) || (md == 2'd3) || (vl == 2'd3);
        n = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
        e.res = '0;
        if (e.bad) e.res = o;
        else begin
            for (int i = 0; i < 8; i++) begin
                if (i >= n)       e.res[32*i +: 32] = '0;
                else if (m[i])    e.res[32*i +: 32] = ref_lane(s[64*i +: 64], md);
                else if (z)       e.res[32*i +: 32] = '0;
                else              e.res[32*i +: 32] = o[32*i +: 32];
            end
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [63:0] pick_val(input int sel);
        case (sel % 10)
            0: return 64'h000000007FFFFFFF;
            1: return 64'h0000000080000000;
            2: return 64'hFFFFFFFF80000000;
            3: return 64'hFFFFFFFF7FFFFFFF;
            4: return 64'h00000000FFFFFFFF;
            5: return 64'h0000000100000000;
            6: return 64'hFFFFFFFFFFFFFFFF;
            7: return 64'h8000000000000000;
            8: return 64'h7FFFFFFFFFFFFFFF;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] rand_val();
        logic [31:0] a;
        a = $urandom;
        case ($urandom % 4)
            0: return {$urandom, $urandom};
            1: return {32'h0, a};
            2: return {{32{a[31]}}, a};
            default: return pick_val(int'($urandom % 10));
        endcase
    endfunction

    function automatic logic [511:0] rand_vec();
        logic [511:0] v;
        for (int i = 0; i < 8; i++) v[64*i +: 64] = rand_val();
        return v;
    endfunction

    // Monitor: pops the oldest expected item whenever a result appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R1 actual=unexpected out_valid expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R6 result"}, dst_vec, e.res);
                check({e.tag, " R9 flag"}, {511'd0, bad_op}, {511'd0, e.bad});
                check("R1 latency", 512'(cyc), 512'(e.cyc + 1));
            end
        end
    end

    initial begin
        logic [511:0] bnd;
        logic [511:0] oldv;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {511'd0, out_valid}, '0);
        check("R1 reset flag", {511'd0, bad_op}, '0);
        check("R1 reset result", dst_vec, '0);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) bnd[64*i +: 64] = pick_val(i);
        for (int i = 0; i < 16; i++) oldv[32*i +: 32] = 32'hA5A50000 + 32'(i);

        issue(bnd, 2'd2, 2'd0, 8'hFF, 1'b0, oldv, 4'hF, "R3 trunc");
        issue(bnd, 2'd2, 2'd1, 8'hFF, 1'b0, oldv, 4'hF, "R4 ssat");
        issue(bnd, 2'd2, 2'd2, 8'hFF, 1'b0, oldv, 4'hF, "R5 usat");
        for (int i = 0; i < 8; i++) bnd[64*i +: 64] = pick_val(i + 2);
        issue(bnd, 2'd2, 2'd1, 8'hFF, 1'b1, oldv, 4'hF, "R4 ssat2");
        issue(bnd, 2'd2, 2'd2, 8'hFF, 1'b1, oldv, 4'hF, "R5 usat2");
        issue(bnd, 2'd0, 2'd0, 8'hFF, 1'b0, oldv, 4'hF, "R2 len128");
        issue(bnd, 2'd1, 2'd1, 8'hFF, 1'b0, oldv, 4'hF, "R2 len256");
        idle(2);
        check("R1 idle", {511'd0, out_valid}, '0);
        issue(bnd, 2'd2, 2'd0, 8'h55, 1'b1, oldv, 4'hF, "R7 zeroing");
        issue(bnd, 2'd2, 2'd2, 8'hA5, 1'b0, oldv, 4'hF, "R8 merging");
        issue(bnd, 2'd0, 2'd0, 8'h01, 1'b0, oldv, 4'hF, "R2 R8 tail");
        issue(bnd, 2'd2, 2'd0, 8'hFF, 1'b0, oldv, 4'b0111, "R9 rsv");
        issue(bnd, 2'd2, 2'd3, 8'hFF, 1'b1, oldv, 4'hF, "R9 mode3");
        issue(bnd, 2'd3, 2'd0, 8'hFF, 1'b1, oldv, 4'hF, "R9 vl3");
        idle(1);

        for (int k = 0; k < 300; k++) begin
            issue(rand_vec(), 2'($urandom % 3), 2'($urandom % 3), 8'($urandom),
                  1'($urandom), {$urandom, $urandom, $urandom, $urandom,
                  $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                  $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
                  ((k % 37) == 5) ? 4'b1110 : 4'hF, "R3 R4 R5 R7 R8 random");
            if ((k % 50) == 49) idle(1);
        end
        idle(3);
        check("R1 drained", 512'(sb.size()), '0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule